// File: doc/BRIEF.md
# Programmable Pixel Sync Edge Detector

This block turns a pixel-rate synchronisation signal into a single-cycle sampling strobe in the master-clock domain. In pass-through mode the incoming signal is expected to already be a one-master-clock-wide pulse, and the block only synchronises it. In detect mode any periodic pixel-rate waveform, for example a sensor shift clock, can drive the input. The block finds the selected edge of that waveform and builds its own one-cycle strobe. That strobe can be held back by zero to seven master-clock cycles.

A second output, `sample_en_o`, marks the cycle in which conversion should take place. That is the first master-clock cycle after the strobe has returned low, whichever way the strobe was produced. The master clock is expected to run at least twice as fast as the pixel sync.

Top module: `pxsync_strobe_gen`

## Requirements
- R1: While reset is asserted, and after reset until two synchronised input samples exist, `strobe_o` and `sample_en_o` are 0.
- R2: With `det_en`=0, `strobe_o` is `sync_in` delayed by two master-clock edges (two-flop synchroniser). A level driven before edge n appears after edge n+1.
- R3: With `det_en`=1 and `rise_sel`=1, a 0-to-1 transition of `sync_in` first sampled at edge n gives `strobe_o`=1 for exactly the one cycle after edge n+2+`dly_sel`.
- R4: With `det_en`=1 and `rise_sel`=0, a 1-to-0 transition of `sync_in` gives the same single-cycle strobe with the same timing.
- R5: The 3-bit `dly_sel` value (0 to 7) adds that many master-clock cycles to the detect-mode strobe timing.
- R6: In detect mode each qualifying edge yields exactly one strobe cycle. Steady levels and edges of the opposite polarity yield none.
- R7: `sample_en_o` is 1 for exactly one cycle, the cycle right after the last cycle in which `strobe_o` was 1.
- R8: Any change of `det_en`, `rise_sel` or `dly_sel` discards detected edges still in flight and the edge history, so no strobe results from them. In detect mode `strobe_o` is 0 in the cycle after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sync_in | input | 1 | Pixel sync pulse or pixel-rate clock |
| det_en | input | 1 | 1: derive strobe by edge detection; 0: pass sync through |
| rise_sel | input | 1 | Edge polarity in detect mode: 1 rising, 0 falling |
| dly_sel | input | DLY_W | Extra strobe delay in master-clock cycles |
| strobe_o | output | 1 | One-cycle pixel sampling strobe |
| sample_en_o | output | 1 | Sample enable, cycle after strobe ends |

## Verification
Every result is counted in rising edges from the edge that first samples a new `sync_in` level. A pass-through strobe is due after the second such edge. A detected strobe is due after edge 3+`dly_sel`, and the sample enable one edge after the strobe drops. Inputs are driven on the falling clock edge and outputs are read on the next falling edge, so each check lands on a settled value in a known cycle. Directed sequences check these cycle counts for every delay value and both polarities. A long random run with toggling periods of 1 to 4 cycles and occasional control changes is compared cycle by cycle against a bench model.

// File: rtl/pxsync_pkg.sv
package pxsync_pkg;

  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } pol_e;

  function automatic logic edge_hit(input pol_e pol, input logic cur, input logic old);
    if (pol == POL_RISE) return cur & ~old;
    else                 return ~cur & old;
  endfunction

endpackage

// File: rtl/pxsync_sync.sv
module pxsync_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_hist,
  input  logic d_in,
  output logic cur_o,
  output logic old_o,
  output logic cur_vld_o,
  output logic old_vld_o
);

  logic s1_q, s2_q, s3_q, v1_q, v2_q, v3_q;
  logic s1_d, s2_d, s3_d, v1_d, v2_d, v3_d;

  always_comb begin
    s1_d = d_in;
    s2_d = s1_q;
    s3_d = s2_q;
    v1_d = 1'b1;
    v2_d = v1_q;
    v3_d = clr_hist ? 1'b0 : v2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0; s2_q <= 1'b0; s3_q <= 1'b0;
      v1_q <= 1'b0; v2_q <= 1'b0; v3_q <= 1'b0;
    end else begin
      s1_q <= s1_d; s2_q <= s2_d; s3_q <= s3_d;
      v1_q <= v1_d; v2_q <= v2_d; v3_q <= v3_d;
    end
  end

  assign cur_o     = s2_q;
  assign old_o     = s3_q;
  assign cur_vld_o = v2_q;
  assign old_vld_o = v3_q;

  // R1
  hist_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    old_vld_o |-> cur_vld_o);

endmodule

// File: rtl/pxsync_dline.sv
module pxsync_dline #(
  parameter int SEL_W = 3,
  localparam int DEPTH = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             tap_o
);

  logic [DEPTH-1:0] line_q;
  logic [DEPTH-1:0] line_d;

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign line_d[i] = clr ? 1'b0 : din;
      end else begin : g_body
        assign line_d[i] = clr ? 1'b0 : line_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= '0;
    else        line_q <= line_d;
  end

  assign tap_o = line_q[sel];

  // R8
  dline_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (line_q == '0));

endmodule

// File: rtl/pxsync_strobe_gen.sv
module pxsync_strobe_gen #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  input  logic             det_en,
  input  logic             rise_sel,
  input  logic [DLY_W-1:0] dly_sel,
  output logic             strobe_o,
  output logic             sample_en_o
);
  import pxsync_pkg::*;

  localparam int CTRL_W = DLY_W + 2;

  logic [CTRL_W-1:0] ctrl_now, ctrl_q;
  logic              ctrl_chg;
  logic              en_q;
  pol_e              pol_q;
  logic [DLY_W-1:0]  dly_q;
  logic              cur, old, cur_vld, old_vld;
  logic              det_pulse, tap, strobe_c, str_q;

  assign ctrl_now = {det_en, rise_sel, dly_sel};
  assign ctrl_chg = (ctrl_now != ctrl_q);
  assign en_q     = ctrl_q[CTRL_W-1];
  assign pol_q    = pol_e'(ctrl_q[CTRL_W-2]);
  assign dly_q    = ctrl_q[DLY_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_now;
  end

  pxsync_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_hist  (ctrl_chg),
    .d_in      (sync_in),
    .cur_o     (cur),
    .old_o     (old),
    .cur_vld_o (cur_vld),
    .old_vld_o (old_vld)
  );

  assign det_pulse = old_vld & edge_hit(pol_q, cur, old);

  pxsync_dline #(.SEL_W(DLY_W)) u_dline (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ctrl_chg),
    .din   (det_pulse),
    .sel   (dly_q),
    .tap_o (tap)
  );

  always_comb begin
    if (en_q) strobe_c = tap;
    else      strobe_c = cur_vld & cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) str_q <= 1'b0;
    else        str_q <= strobe_c;
  end

  assign strobe_o    = strobe_c;
  assign sample_en_o = str_q & ~strobe_c;

  // R8
  ctrl_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (det_en && ctrl_chg) |=> !strobe_o);

  // R3
  zero_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && dly_q == '0 && !ctrl_chg && det_pulse) |=> strobe_o);

  // R7
  se_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> sample_en_o);

  // R7
  se_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en_o |=> !sample_en_o);

endmodule

// File: tb/pxsync_strobe_gen_tb.sv
module pxsync_strobe_gen_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sync_in, det_en, rise_sel;
  logic [2:0] dly_sel;
  logic       strobe_o, sample_en_o;
  int         tests = 0;
  int         fails = 0;

  always #10 clk = ~clk;

  pxsync_strobe_gen #(.DLY_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .det_en(det_en),
    .rise_sel(rise_sel), .dly_sel(dly_sel),
    .strobe_o(strobe_o), .sample_en_o(sample_en_o)
  );

  // bench model of the required timing
  logic       m_s1, m_s2, m_s3, m_v1, m_v2, m_v3, m_en, m_pol, m_sd;
  logic [2:0] m_dly;
  logic [7:0] m_line;
  logic       m_chg, m_det, m_es;

  function automatic logic exp_strobe();
    return m_en ? m_line[m_dly] : (m_v2 & m_s2);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_v1 = 0; m_v2 = 0; m_v3 = 0;
      m_en = 0; m_pol = 0; m_dly = 0; m_sd = 0; m_line = 0;
    end else begin
      m_chg  = {det_en, rise_sel, dly_sel} != {m_en, m_pol, m_dly};
      m_det  = m_v3 && (m_pol ? (m_s2 && !m_s3) : (!m_s2 && m_s3));
      m_es   = exp_strobe();
      m_sd   = m_es;
      m_line = m_chg ? 8'h00 : {m_line[6:0], m_det};
      m_v3   = m_chg ? 1'b0 : m_v2;
      m_v2   = m_v1; m_v1 = 1'b1;
      m_s3   = m_s2; m_s2 = m_s1; m_s1 = sync_in;
      m_en   = det_en; m_pol = rise_sel; m_dly = dly_sel;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seed;
    int half;
    seed = 7;
    void'($urandom(seed));
    rst_n = 0; sync_in = 1; det_en = 0; rise_sel = 0; dly_sel = 0;
    repeat (3) step();
    chk("R1 strobe in reset", strobe_o, 1'b0);
    chk("R1 sample_en in reset", sample_en_o, 1'b0);
    rst_n = 1;
    step();
    chk("R1 strobe before two samples", strobe_o, 1'b0);
    step();
    chk("R2 pass-through level after 2 edges", strobe_o, 1'b1);

    // R2 R7: pass-through single pulse
    sync_in = 0; repeat (4) step();
    sync_in = 1; step();
    chk("R2 pulse not yet", strobe_o, 1'b0);
    sync_in = 0; step();
    chk("R2 pulse out", strobe_o, 1'b1);
    step();
    chk("R2 pulse ended", strobe_o, 1'b0);
    chk("R7 sample_en after pass pulse", sample_en_o, 1'b1);
    step();
    chk("R7 sample_en one cycle", sample_en_o, 1'b0);

    // R3 R5 R6 R7: rising edges, every delay
    for (int d = 0; d < 8; d++) begin
      sync_in = 0; det_en = 1; rise_sel = 1; dly_sel = 3'(d);
      repeat (5) step();
      sync_in = 1;
      for (int k = 1; k <= 12; k++) begin
        step();
        chk("R5 rising strobe timing", strobe_o, 1'(k == 3 + d));
        chk("R7 sample_en timing", sample_en_o, 1'(k == 4 + d));
      end
      sync_in = 0;
      for (int k = 1; k <= 12; k++) begin
        step();
        chk("R6 opposite edge ignored", strobe_o, 1'b0);
      end
    end

    // R4: falling edge, delay 2
    sync_in = 1; det_en = 1; rise_sel = 0; dly_sel = 3'd2;
    repeat (5) step();
    sync_in = 0;
    for (int k = 1; k <= 12; k++) begin
      step();
      chk("R4 falling strobe timing", strobe_o, 1'(k == 5));
    end

    // R8: control change drops an edge in flight
    sync_in = 0; rise_sel = 1; dly_sel = 3'd7;
    repeat (5) step();
    sync_in = 1;
    repeat (4) step();
    dly_sel = 3'd6;
    for (int k = 1; k <= 12; k++) begin
      step();
      chk("R8 flushed edge gives no strobe", strobe_o, 1'b0);
    end

    // random phase against model
    half = 1;
    for (int c = 0; c < 4000; c++) begin
      chk(m_en ? "R5 random detect strobe" : "R2 random pass strobe", strobe_o, exp_strobe());
      chk("R7 random sample_en", sample_en_o, m_sd & ~exp_strobe());
      half--;
      if (half == 0) begin
        sync_in = ~sync_in;
        half = 1 + int'($urandom_range(3));
      end
      if ($urandom_range(63) == 0) begin
        det_en = 1'($urandom); rise_sel = 1'($urandom); dly_sel = 3'($urandom);
      end
      step();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule